// File: doc/BRIEF.md
# Odd-Ratio Half-Duty Clock Divider

This block takes a reference clock and produces a clock whose frequency is the reference divided by a fixed odd integer, set at elaboration through a parameter (3, 5, 7 and so on). The output is high for exactly half of its period, although that period is an odd number of reference cycles. To get this, the block uses both edges of the reference clock.

A modulo counter advances on every rising edge of the reference. Two toggle stages each run at half the output frequency. One toggles on a rising edge, when the counter is at zero. The other toggles on a falling edge, when the counter holds the midpoint value, which is one more than half the ratio rounded down. The two toggles are a quarter of their period apart, so only one of them changes at any instant. Their exclusive-OR is the divided clock, and it carries no glitches.

An active-high synchronous reset clears every stage. The rising-edge stages sample reset on the rising edge and the falling-edge stage samples it on the falling edge. Once reset is released, the output waveform starts from a known phase.

Top module: `odd_clk_divider`

## Requirements
- R1: While reset is held, the divided clock is low from the first falling reference edge at which reset is sampled high.
- R2: After reset is released, the divided clock goes high at the first rising reference edge at which reset is sampled low.
- R3: Each high phase of the divided clock lasts DIV_N half reference periods, which is DIV_N/2 reference periods.
- R4: The divided clock has a period of exactly DIV_N reference periods.
- R5: The divided clock goes high only at rising reference edges and goes low only at falling reference edges.
- R6: The internal count runs 0, 1, …, DIV_N-1 and then wraps to 0. It advances once per rising reference edge.
- R7: Asserting reset in the middle of a run and releasing it again restarts the waveform, which then behaves as in R2.
- R8: A DIV_N that is even or smaller than 3 is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock. It needs a 50% duty cycle for the output to have an exact 50% duty cycle. |
| rst | input | 1 | Active-high synchronous reset, sampled on both reference edges |
| clk_div | output | 1 | Divided clock, reference frequency divided by DIV_N, 50% duty cycle |

## Verification
The assertions take for granted that reset changes only away from both reference edges, so that the rising-edge and falling-edge stages agree on its value. They also assume that the reference toggles with a constant half period. The stimulus sets and clears reset a short time after a falling edge, and uses one fixed-period clock. The divided clock is sampled in the middle of each half period, never on an edge, so every sample sees a settled level.

// File: rtl/odd_div_pkg.sv
package odd_div_pkg;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_sel_e;

  // Count value at which the falling-edge stage toggles: floor(n/2)+1.
  function automatic int fall_match(input int n);
    return (n / 2) + 1;
  endfunction

  function automatic bit ratio_ok(input int n);
    return (n >= 3) && ((n % 2) == 1);
  endfunction

endpackage

// File: rtl/odd_div_counter.sv
module odd_div_counter #(
  parameter int DIV_N = 5,
  parameter int CNT_W = $clog2(DIV_N)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_N - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/odd_div_toggle.sv
module odd_div_toggle
  import odd_div_pkg::*;
#(
  parameter edge_sel_e EDGE  = EDGE_RISE,
  parameter int        CNT_W = 2,
  parameter int        MATCH = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             tog_o
);

  localparam logic [CNT_W-1:0] MATCH_V = CNT_W'(MATCH);

  logic tog_q;
  logic hit;

  assign hit = (cnt_i == MATCH_V);

  generate
    if (EDGE == EDGE_RISE) begin : g_rise
      always_ff @(posedge clk) begin
        if (rst) begin
          tog_q <= 1'b0;
        end else if (hit) begin
          tog_q <= ~tog_q;
        end
      end
    end else begin : g_fall
      // Samples the count registered on the previous rising edge.
      always_ff @(negedge clk) begin
        if (rst) begin
          tog_q <= 1'b0;
        end else if (hit) begin
          tog_q <= ~tog_q;
        end
      end
    end
  endgenerate

  assign tog_o = tog_q;

endmodule

// File: rtl/odd_clk_divider.sv
module odd_clk_divider
  import odd_div_pkg::*;
#(
  parameter int DIV_N = 5
) (
  input  logic clk_ref,
  input  logic rst,
  output logic clk_div
);

  localparam int CNT_W    = $clog2(DIV_N);
  localparam int RISE_HIT = 0;
  localparam int FALL_HIT = fall_match(DIV_N);

  // R8: reject ratios the scheme cannot serve
  generate
    if (!ratio_ok(DIV_N)) begin : g_bad_ratio
      $error("odd_clk_divider: DIV_N must be odd and at least 3");
    end
  endgenerate

  logic [CNT_W-1:0] cnt_q;
  logic             tog_rise;
  logic             tog_fall;

  odd_div_counter #(
    .DIV_N (DIV_N),
    .CNT_W (CNT_W)
  ) cnt_i (
    .clk   (clk_ref),
    .rst   (rst),
    .cnt_o (cnt_q)
  );

  odd_div_toggle #(
    .EDGE  (EDGE_RISE),
    .CNT_W (CNT_W),
    .MATCH (RISE_HIT)
  ) tog_rise_i (
    .clk   (clk_ref),
    .rst   (rst),
    .cnt_i (cnt_q),
    .tog_o (tog_rise)
  );

  odd_div_toggle #(
    .EDGE  (EDGE_FALL),
    .CNT_W (CNT_W),
    .MATCH (FALL_HIT)
  ) tog_fall_i (
    .clk   (clk_ref),
    .rst   (rst),
    .cnt_i (cnt_q),
    .tog_o (tog_fall)
  );

  // Quadrature toggles: only one input changes per edge.
  assign clk_div = tog_rise ^ tog_fall;

endmodule

// File: rtl/odd_clk_divider_chk.sv
module odd_clk_divider_chk #(
  parameter int DIV_N = 5,
  parameter int CNT_W = 3
) (
  input logic             clk_ref,
  input logic             rst,
  input logic             clk_div,
  input logic [CNT_W-1:0] cnt_q,
  input logic             tog_r,
  input logic             tog_f
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_N - 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'((DIV_N / 2) + 1);

  assert_count_range_R6: assert property (@(posedge clk_ref) disable iff (rst)
    cnt_q <= LAST);

  assert_count_wrap_R6: assert property (@(posedge clk_ref) disable iff (rst)
    (cnt_q == LAST) |=> (cnt_q == '0));

  assert_count_step_R6: assert property (@(posedge clk_ref) disable iff (rst)
    (cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R2 / R5: the rising-edge stage changes only when the count is zero
  assert_rise_toggle_R5: assert property (@(posedge clk_ref) disable iff (rst)
    (cnt_q == '0) |=> (tog_r != $past(tog_r)));

  assert_rise_hold_R5: assert property (@(posedge clk_ref) disable iff (rst)
    (cnt_q != '0) |=> $stable(tog_r));

  // R3: the falling-edge stage changes only at the midpoint count
  assert_fall_toggle_R3: assert property (@(negedge clk_ref) disable iff (rst)
    (cnt_q == MID) |=> (tog_f != $past(tog_f)));

  assert_fall_hold_R3: assert property (@(negedge clk_ref) disable iff (rst)
    (cnt_q != MID) |=> $stable(tog_f));

  assert_low_in_reset_R1: assert property (@(posedge clk_ref)
    (rst && $past(rst)) |-> !clk_div);

endmodule

bind odd_clk_divider odd_clk_divider_chk #(
  .DIV_N (DIV_N),
  .CNT_W (CNT_W)
) chk_i (
  .clk_ref (clk_ref),
  .rst     (rst),
  .clk_div (clk_div),
  .cnt_q   (cnt_q),
  .tog_r   (tog_rise),
  .tog_f   (tog_fall)
);

// File: tb/odd_clk_divider_tb_top.sv
`timescale 1ns/1ps
module odd_clk_divider_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic div5, div3, div7;
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;

  always #5 clk = ~clk;

  odd_clk_divider #(.DIV_N(5)) dut_i  (.clk_ref(clk), .rst(rst), .clk_div(div5));
  odd_clk_divider #(.DIV_N(3)) dut3_i (.clk_ref(clk), .rst(rst), .clk_div(div3));
  odd_clk_divider #(.DIV_N(7)) dut7_i (.clk_ref(clk), .rst(rst), .clk_div(div7));

  task automatic check(input string req, input int n, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s (N=%0d) at %0t: actual=%b expected=%b", req, n, $time, act, exp);
    end
  endtask

  task automatic check_int(input string req, input int n, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s (N=%0d) at %0t: actual=%0d expected=%0d", req, n, $time, act, exp);
    end
  endtask

  // Expected level in half-period h after the first post-reset rising edge.
  function automatic logic exp_level(input int n, input int h);
    return ((h / n) % 2) == 0;
  endfunction

  function automatic string tag_for(input string pfx, input int n, input int h);
    if (h == 0) return {pfx, " R2 first rise"};
    if ((h % n) == 0) return {pfx, " R5 edge"};
    return {pfx, " R3 level"};
  endfunction

  // Release reset and compare each half period against the ideal waveform.
  task automatic run_pattern(input string pfx, input int halves);
    @(negedge clk);
    #1 rst = 1'b0;
    @(posedge clk);
    #2;
    for (int h = 0; h < halves; h++) begin
      check(tag_for(pfx, 3, h), 3, div3, exp_level(3, h));
      check(tag_for(pfx, 5, h), 5, div5, exp_level(5, h));
      check(tag_for(pfx, 7, h), 7, div7, exp_level(7, h));
      #5;
    end
  endtask

  task automatic test_reset_low();
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset low (high half)", 3, div3, 1'b0);
    check("R1 reset low (high half)", 5, div5, 1'b0);
    check("R1 reset low (high half)", 7, div7, 1'b0);
    #5;
    check("R1 reset low (low half)", 3, div3, 1'b0);
    check("R1 reset low (low half)", 5, div5, 1'b0);
    check("R1 reset low (low half)", 7, div7, 1'b0);
  endtask

  // Free-running measurement of period and high time, independent of phase.
  task automatic test_period();
    int last_rise [3];
    int high_run  [3];
    int rises     [3];
    logic prev    [3];
    logic cur     [3];
    int   nn      [3];
    nn = '{3, 5, 7};
    for (int k = 0; k < 3; k++) begin
      last_rise[k] = -1; high_run[k] = 0; rises[k] = 0; prev[k] = 1'b1;
    end
    @(posedge clk);
    #2;
    for (int h = 0; h < 8 * 7; h++) begin
      cur = '{div3, div5, div7};
      for (int k = 0; k < 3; k++) begin
        if (cur[k] && !prev[k]) begin
          if (last_rise[k] >= 0)
            check_int("R4 period in half periods", nn[k], h - last_rise[k], 2 * nn[k]);
          last_rise[k] = h;
          rises[k]++;
          high_run[k] = 1;
        end else if (cur[k] && rises[k] > 0) begin
          high_run[k]++;
        end else if (!cur[k] && prev[k] && rises[k] > 0) begin
          check_int("R3 high time in half periods", nn[k], high_run[k], nn[k]);
        end
        prev[k] = cur[k];
      end
      #5;
    end
  endtask

  task automatic test_midrun_reset();
    @(negedge clk);
    #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    #2;
    check("R7 mid-run reset low", 3, div3, 1'b0);
    check("R7 mid-run reset low", 5, div5, 1'b0);
    check("R7 mid-run reset low", 7, div7, 1'b0);
    run_pattern("R7 restart", 4 * 7);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired at %0t: actual=running expected=done", $time);
      finish_run();
    end
  end

  initial begin
    test_reset_low();
    run_pattern("R2", 6 * 7);
    test_period();
    test_midrun_reset();
    // Hold reset across a partial output period, then release again (R7).
    repeat (4) @(posedge clk);
    test_midrun_reset();
    done = 1'b1;
    finish_run();
  end

endmodule